// File: doc/BRIEF.md
# CAN Receive Bit Sampler and Destuffer

This block sits right behind the input synchronizer of a CAN receiver. It watches one receive line that has already been synchronized to the system clock. While idle it waits for the line to go dominant (logic 0). The first dominant cycle is taken as the time origin of a new frame, and a one-cycle frame-start pulse is issued.

From that origin the block samples the line once per bit period. The sample point is a fixed fraction of the bit period, set at elaboration time. Every raw bit is checked against the five raw bits before it. A bit that breaks a run of five equal bits is a stuff bit. It is reported on a one-cycle flag and is not forwarded.

All other bits are handed to a downstream frame parser, each with a valid strobe and its index among the non-stuff bits of the frame. The parser decides where the frame ends. It returns the block to idle with an end-of-frame request. Sample instants are computed only from the start-of-frame origin. No later edge moves them.

Top module: `can_bit_destuffer`

## Requirements
- R1: After reset every output is low, `bit_index` is zero, and the block is idle, waiting for a dominant line.
- R2: In idle, the first clock edge that sees `rx_line` low starts a frame, and `frame_start` is high for exactly the following cycle. While `rx_line` stays high in idle, no output is ever raised.
- R3: Raw bit n (n = 0 for the start-of-frame bit) is taken at the clock edge that is n·CYC_PER_BIT + OFFSET edges after the start-of-frame edge. OFFSET = floor(CYC_PER_BIT·SAMPLE_PCT/100), so 7 for CYC_PER_BIT=10 and SAMPLE_PCT=75. The result (`bit_valid` or `stuff_flag`) is visible in the cycle after that edge.
- R4: A raw bit that is not a stuff bit produces one cycle of `bit_valid`. In that cycle `bit_value` holds the sampled level and `bit_index` holds its position among the non-stuff bits of the frame, starting at 0 and rising by one per forwarded bit.
- R5: A raw bit is a stuff bit when the five raw bits before it are all 0 and it is 1, or all 1 and it is 0. A stuff bit raises `stuff_flag` for one cycle instead of `bit_valid`, and it leaves the index of the next forwarded bit unchanged.
- R6: The five-bit comparison window covers raw bits, stuff bits included. A stuff bit therefore counts toward the next run.
- R7: A sixth equal bit that follows five equal bits is not a stuff bit. It is forwarded as data, and it opens a new window.
- R8: No bit is judged a stuff bit until five raw bits of the current frame have been taken.
- R9: `eof_req` high at a clock edge returns the block to idle and clears the bit history, the counters and the time origin. Any sample due at that edge is dropped, and no output rises in the next cycle. The next frame starts again at index 0 with an empty history.
- R10: `frame_start` pulses once per frame. Dominant edges inside a running frame do not raise it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Synchronized receive line, 0 = dominant |
| eof_req | input | 1 | Return-to-idle request from the frame parser |
| frame_start | output | 1 | One-cycle pulse after the start-of-frame edge |
| bit_valid | output | 1 | One-cycle strobe for a forwarded (non-stuff) bit |
| bit_value | output | 1 | Level of the forwarded bit |
| bit_index | output | IDX_W | Position of the forwarded bit in the frame, stuff bits excluded |
| stuff_flag | output | 1 | One-cycle strobe marking a removed stuff bit |

## Verification
The raw streams fed to the block include alternating bits with no stuffing at all, a plain five-zero run broken by a one, and a five-one run broken by a zero. These show that both stuff polarities are recognized. A run of six zeros checks that equality alone never marks a stuff bit. Two streams contain chained runs in which a stuff bit opens the next run. These separate a window over raw bits from one over forwarded bits. A stream of four zeros followed by ones tests the five-bit threshold.

One frame is cut short by an end-of-frame request after five zeros. It is followed by a frame whose second bit is 1. A history left over from the cut frame would wrongly turn that bit into a stuff bit. For every raw bit the bench also checks the cycle offset of its strobe from `frame_start`, using a truncated sample percentage.

// File: rtl/can_ds_pkg.sv
package can_ds_pkg;

   typedef enum logic {
      RX_IDLE = 1'b0,
      RX_RUN  = 1'b1
   } rx_state_e;

   // Sample offset inside a bit period, truncated toward zero.
   function automatic int unsigned sample_offset(input int unsigned cyc,
                                                 input int unsigned pct);
      return (cyc * pct) / 100;
   endfunction

endpackage

// File: rtl/can_ds_timer.sv
module can_ds_timer
   import can_ds_pkg::*;
#(
   parameter int unsigned CYC_PER_BIT = 20,
   parameter int unsigned SAMPLE_PCT  = 70
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic clr_i,
   output logic sof_o,
   output logic smp_o
);

   localparam int unsigned OFFSET = sample_offset(CYC_PER_BIT, SAMPLE_PCT);
   localparam int unsigned PW     = $clog2(CYC_PER_BIT);
   localparam logic [PW-1:0] LAST = PW'(CYC_PER_BIT - 1);
   localparam logic [PW-1:0] OFFS = PW'(OFFSET);
   localparam logic [PW-1:0] ONE  = PW'(1);

   initial begin : param_chk
      assert (CYC_PER_BIT >= 4) else $error("CYC_PER_BIT must be at least 4");
      assert (SAMPLE_PCT >= 1 && SAMPLE_PCT <= 99) else $error("SAMPLE_PCT out of 1..99");
      assert (OFFSET >= 1) else $error("sample offset truncates to zero");
   end

   rx_state_e       state_q;
   logic [PW-1:0]   phase_q;   // elapsed cycles since origin, modulo bit period

   assign sof_o = (state_q == RX_IDLE) && !line_i && !clr_i;
   assign smp_o = (state_q == RX_RUN) && (phase_q == OFFS) && !clr_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         phase_q <= '0;
      end else if (clr_i) begin
         state_q <= RX_IDLE;
         phase_q <= '0;
      end else if (state_q == RX_IDLE) begin
         if (!line_i) begin
            state_q <= RX_RUN;
            phase_q <= ONE;
         end
      end else begin
         phase_q <= (phase_q == LAST) ? '0 : phase_q + ONE;
      end
   end

   // Checker counter: cycles since the origin or the last sample.
   logic [31:0] gap_q;
   logic        seen_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (clr_i) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (sof_o) begin
         gap_q  <= 32'd1;
         seen_q <= 1'b0;
      end else if (smp_o) begin
         gap_q  <= 32'd1;
         seen_q <= 1'b1;
      end else begin
         gap_q  <= gap_q + 32'd1;
      end
   end

   // R3
   sample_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_o |-> gap_q == (seen_q ? 32'(CYC_PER_BIT) : 32'(OFFSET)));

endmodule

// File: rtl/can_ds_unstuff.sv
module can_ds_unstuff #(
   parameter int unsigned RUN_LEN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic sof_i,
   input  logic smp_i,
   input  logic line_i,
   output logic stuff_o
);

   localparam int unsigned CW = $clog2(RUN_LEN + 1);
   localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

   initial begin : param_chk
      assert (RUN_LEN >= 2) else $error("RUN_LEN must be at least 2");
   end

   logic [RUN_LEN-1:0] hist_q;   // newest raw bit in bit 0
   logic [CW-1:0]      fill_q;
   logic               all_zero, all_one, full;

   // Run detection: every bit of the history equal to the newest one.
   logic [RUN_LEN-1:0] same;
   assign same[0] = 1'b1;
   genvar g;
   generate
      for (g = 1; g < RUN_LEN; g++) begin : g_same
         assign same[g] = (hist_q[g] == hist_q[0]);
      end
   endgenerate

   assign full     = (fill_q == FULL);
   assign all_zero = (&same) && !hist_q[0];
   assign all_one  = (&same) &&  hist_q[0];
   assign stuff_o  = smp_i && full && ((all_zero && line_i) || (all_one && !line_i));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '0;
         fill_q <= '0;
      end else if (clr_i || sof_i) begin
         hist_q <= '0;
         fill_q <= '0;
      end else if (smp_i) begin
         hist_q <= {hist_q[RUN_LEN-2:0], line_i};
         if (!full) fill_q <= fill_q + CW'(1);
      end
   end

   // R5
   stuff_breaks_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stuff_o && !clr_i |=> hist_q[0] != hist_q[1]);

endmodule

// File: rtl/can_ds_emit.sv
module can_ds_emit #(
   parameter int unsigned IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             sof_i,
   input  logic             smp_i,
   input  logic             stuff_i,
   input  logic             line_i,
   output logic             frame_start_o,
   output logic             bit_valid_o,
   output logic             bit_value_o,
   output logic [IDX_W-1:0] bit_index_o,
   output logic             stuff_flag_o
);

   logic [IDX_W-1:0] next_idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         frame_start_o <= 1'b0;
         bit_valid_o   <= 1'b0;
         bit_value_o   <= 1'b0;
         bit_index_o   <= '0;
         stuff_flag_o  <= 1'b0;
         next_idx_q    <= '0;
      end else begin
         frame_start_o <= sof_i;
         bit_valid_o   <= smp_i && !stuff_i;
         stuff_flag_o  <= smp_i && stuff_i;
         if (sof_i) begin
            next_idx_q  <= '0;
            bit_index_o <= '0;
         end else if (smp_i && !stuff_i) begin
            bit_value_o <= line_i;
            bit_index_o <= next_idx_q;
            next_idx_q  <= next_idx_q + IDX_W'(1);
         end
      end
   end

   // Checker state: last forwarded index within this frame.
   logic [IDX_W-1:0] last_q;
   logic             have_q;
   always_ff @(posedge clk) begin
      if (!rst_n || clr_i || sof_i) begin
         last_q <= '0;
         have_q <= 1'b0;
      end else if (bit_valid_o) begin
         last_q <= bit_index_o;
         have_q <= 1'b1;
      end
   end

   // R4
   index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid_o && have_q |-> bit_index_o == last_q + IDX_W'(1));

   // R10
   single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o |=> !frame_start_o);

endmodule

// File: rtl/can_bit_destuffer.sv
module can_bit_destuffer #(
   parameter int unsigned CYC_PER_BIT = 20,
   parameter int unsigned SAMPLE_PCT  = 70,
   parameter int unsigned RUN_LEN     = 5,
   parameter int unsigned IDX_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_line,
   input  logic             eof_req,
   output logic             frame_start,
   output logic             bit_valid,
   output logic             bit_value,
   output logic [IDX_W-1:0] bit_index,
   output logic             stuff_flag
);

   logic sof, smp, stuff;

   can_ds_timer #(
      .CYC_PER_BIT (CYC_PER_BIT),
      .SAMPLE_PCT  (SAMPLE_PCT)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (rx_line),
      .clr_i  (eof_req),
      .sof_o  (sof),
      .smp_o  (smp)
   );

   can_ds_unstuff #(
      .RUN_LEN (RUN_LEN)
   ) u_unstuff (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (eof_req),
      .sof_i   (sof),
      .smp_i   (smp),
      .line_i  (rx_line),
      .stuff_o (stuff)
   );

   can_ds_emit #(
      .IDX_W (IDX_W)
   ) u_emit (
      .clk           (clk),
      .rst_n         (rst_n),
      .clr_i         (eof_req),
      .sof_i         (sof),
      .smp_i         (smp),
      .stuff_i       (stuff),
      .line_i        (rx_line),
      .frame_start_o (frame_start),
      .bit_valid_o   (bit_valid),
      .bit_value_o   (bit_value),
      .bit_index_o   (bit_index),
      .stuff_flag_o  (stuff_flag)
   );

   // R2
   start_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> !bit_valid && !stuff_flag);

   // R9
   eof_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eof_req |=> !bit_valid && !stuff_flag && !frame_start);

   // R5
   valid_stuff_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bit_valid && stuff_flag));

endmodule

// File: tb/can_bit_destuffer_test.sv
`timescale 1ns/1ps
module can_bit_destuffer_test;

   localparam int CYC = 10;
   localparam int PCT = 75;
   localparam int OFF = 7;     // floor(10*75/100), worked out by hand
   localparam int IW  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_line = 1'b1;
   logic          eof_req = 1'b0;
   logic          frame_start, bit_valid, bit_value, stuff_flag;
   logic [IW-1:0] bit_index;

   can_bit_destuffer #(.CYC_PER_BIT(CYC), .SAMPLE_PCT(PCT), .RUN_LEN(5), .IDX_W(IW)) uut (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .eof_req(eof_req),
      .frame_start(frame_start), .bit_valid(bit_valid), .bit_value(bit_value),
      .bit_index(bit_index), .stuff_flag(stuff_flag));

   always #2 clk = ~clk;   // 250 MHz

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   // Vector layout: {length, expected stuff count, raw bits right-aligned,
   // first transmitted bit is the leftmost of the length}.
   localparam logic [63:0] VEC [7] = '{
      {8'd16, 8'd0, 48'b0101010101010101},   // R4 no stuffing
      {8'd10, 8'd1, 48'b0000010110},         // R5 zero run
      {8'd15, 8'd2, 48'b000001111101010},    // R6 chained runs
      {8'd11, 8'd1, 48'b00000010101},        // R7 six zeros
      {8'd9,  8'd1, 48'b011111011},          // R5 one run
      {8'd8,  8'd0, 48'b00001111},           // R8 short run
      {8'd12, 8'd2, 48'b011111000001}        // R6 stuff opens zero run
   };

   // Event log, filled at the falling edge.
   int          cyc = 0;
   int          fs_cyc = 0;
   int          fs_cnt = 0;
   int          n_ev = 0;
   logic        ev_val   [64];
   logic        ev_stuff [64];
   int          ev_idx   [64];
   int          ev_off   [64];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (frame_start) begin
         fs_cnt = fs_cnt + 1;
         fs_cyc = cyc;
      end
      if ((bit_valid || stuff_flag) && n_ev < 64) begin
         ev_val[n_ev]   = bit_value;
         ev_stuff[n_ev] = stuff_flag;
         ev_idx[n_ev]   = int'(bit_index);
         ev_off[n_ev]   = cyc - fs_cyc;
         n_ev = n_ev + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic clear_log();
      n_ev = 0;
      fs_cnt = 0;
   endtask

   task automatic send_bits(input logic [47:0] raw, input int len);
      for (int i = 0; i < len; i++) begin
         rx_line = raw[len-1-i];
         repeat (CYC) @(negedge clk);
      end
      rx_line = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic end_frame();
      eof_req = 1'b1;
      @(negedge clk);
      eof_req = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   // Compare the log against a model built from R3..R8.
   task automatic verify(input logic [47:0] raw, input int len, input int nst_exp,
                         input string tag);
      int  nst = 0, idx = 0, bad_val = 0, bad_idx = 0, bad_tim = 0, bad_st = 0;
      for (int i = 0; i < len && i < n_ev; i++) begin
         logic b, st;
         b  = raw[len-1-i];
         st = 1'b0;
         if (i >= 5) begin
            logic z = 1'b1, o = 1'b1;
            for (int k = i-5; k < i; k++) begin
               if (raw[len-1-k])  z = 1'b0;
               if (!raw[len-1-k]) o = 1'b0;
            end
            st = (z && b) || (o && !b);
         end
         if (st) nst++;
         if (ev_stuff[i] !== st) bad_st++;
         if (ev_off[i] != i*CYC + OFF) bad_tim++;
         if (!st) begin
            if (ev_val[i] !== b) bad_val++;
            if (ev_idx[i] != idx) bad_idx++;
            idx++;
         end
      end
      chk(nst == nst_exp, "R5", {tag, " model stuff count vs table"}, nst, nst_exp);
      chk(n_ev == len, "R3", {tag, " one strobe per raw bit"}, n_ev, len);
      chk(bad_st == 0, "R5", {tag, " stuff flag placement"}, bad_st, 0);
      chk(bad_tim == 0, "R3", {tag, " sample timing"}, bad_tim, 0);
      chk(bad_val == 0, "R4", {tag, " forwarded values"}, bad_val, 0);
      chk(bad_idx == 0, "R4", {tag, " forwarded indices"}, bad_idx, 0);
      chk(fs_cnt == 1, "R10", {tag, " frame_start count"}, fs_cnt, 1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(!frame_start && !bit_valid && !bit_value && !stuff_flag && bit_index == '0,
          "R1", "outputs after reset",
          int'({frame_start, bit_valid, bit_value, stuff_flag}) + int'(bit_index), 0);
      rst_n = 1'b1;
      clear_log();
      repeat (40) @(negedge clk);
      // R2 idle with recessive line
      chk(n_ev == 0 && fs_cnt == 0, "R2", "idle activity", n_ev + fs_cnt, 0);

      for (int v = 0; v < 7; v++) begin
         clear_log();
         send_bits(VEC[v][47:0], int'(VEC[v][63:56]));
         end_frame();
         verify(VEC[v][47:0], int'(VEC[v][63:56]), int'(VEC[v][55:48]),
                $sformatf("vec%0d", v));
      end

      // R9 cut a frame short after five zeros, then restart
      clear_log();
      rx_line = 1'b0;
      repeat (5*CYC) @(negedge clk);
      rx_line = 1'b1;
      end_frame();
      repeat (20) @(negedge clk);
      chk(n_ev == 5, "R9", "strobes before abort and none after", n_ev, 5);
      chk(fs_cnt == 1, "R9", "no restart on recessive line", fs_cnt, 1);
      clear_log();
      send_bits(48'b01000001, 8);
      end_frame();
      chk(n_ev > 1 && !ev_stuff[1] && ev_val[1] === 1'b1, "R9",
          "history cleared, bit1 forwarded", n_ev > 1 ? int'(ev_stuff[1]) : -1, 0);
      chk(n_ev > 0 && ev_idx[0] == 0, "R9", "index restarts at 0",
          n_ev > 0 ? ev_idx[0] : -1, 0);
      verify(48'b01000001, 8, 1, "restart");

      // R9 nothing after return to idle with recessive line
      clear_log();
      repeat (30) @(negedge clk);
      chk(n_ev == 0 && fs_cnt == 0, "R9", "quiet after end of frame", n_ev + fs_cnt, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule